// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block moves a small 16-bit segmented processor core into an interrupt handler and later brings it back. It takes an entry request with an 8-bit vector number and a source tag, which is hardware, trap or exception. It then saves the machine state on a word-wide stack in memory. The flags go first, then the return segment, then the return offset. Next it fetches the handler address from a vector table that sits at physical address zero. Finally it hands the new segment, offset and flags back to the core.

A return request undoes the entry. It reads the offset, the segment and the flags back from the stack, in that order. The flags are restored together with the address.

The block owns a simple synchronous memory port that carries one word access per cycle. A read returns its data one cycle after it is issued. The core supplies its current segment, offset, flags and stack registers as inputs. It takes over the new values when the block raises a one-cycle completion pulse.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry request seen while the block is idle is accepted in these cases. With source tag 2'b00 (hardware), it is accepted only when bit 9 of `cur_flags` (interrupt enable) is 1. With tags 2'b01 (trap), 2'b10 (exception) and 2'b11 (treated as non-hardware), it is accepted regardless of that bit. When entry and return are requested in the same idle cycle, an acceptable entry wins. A masked hardware request leaves the block idle and makes no memory access.
- R2: After entry is accepted, the first three cycles each write one word. The flags go to SS:SP-2, the return segment to SS:SP-4 and the return offset to SS:SP-6. Offsets wrap modulo 2^16, and the physical address is segment*16 + offset. The reported `new_sp` is SP-6.
- R3: After the pushes, two reads are issued in consecutive cycles. The first is at physical address vector*4 (the handler offset). The second is at vector*4+2 (the handler segment). Both reads use segment 0.
- R4: At completion of an entry, `new_ip` equals the word read at vector*4 and `new_cs` equals the word read at vector*4+2.
- R5: On a hardware entry, `new_flags` is the saved flags with bit 9 cleared. On any other entry, `new_flags` equals the saved flags unchanged.
- R6: After a return is accepted, three reads are issued in consecutive cycles at SS:SP, SS:SP+2 and SS:SP+4. These reads supply `new_ip`, `new_cs` and `new_flags`, and `new_sp` is SP+6. An entry followed by a return gives back the original flags, segment, offset and stack pointer.
- R7: `busy` is high from the cycle after acceptance through the completion cycle, and is low in the cycle after that. Entry and return requests made while `busy` is high are ignored. Memory accesses occur only while `busy` is high.
- R8: `done` is high for exactly one cycle. That cycle is the 7th cycle after the accepting edge for an entry and the 5th cycle for a return.
- R9: After reset, `busy`, `done` and `mem_req` are low, and `new_cs`, `new_ip`, `new_flags` and `new_sp` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enter_req | input | 1 | Request to enter a handler |
| enter_vec | input | 8 | Vector number for the entry |
| enter_kind | input | 2 | Source tag: 00 hardware, 01 trap, 10 exception |
| ret_req | input | 1 | Request to return from a handler |
| cur_cs | input | 16 | Current code segment of the core |
| cur_ip | input | 16 | Current instruction offset (the return offset) |
| cur_flags | input | 16 | Current flags; bit 9 is interrupt enable |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access strobe for this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after the read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_cs | output | 16 | Code segment for the core to load |
| new_ip | output | 16 | Instruction offset for the core to load |
| new_flags | output | 16 | Flags for the core to load |
| new_sp | output | 16 | Stack pointer for the core to load |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of a running sequence. In that case the saved state and the vector must stay those of the first request, even though the inputs now carry different values. The stimulus reaches it by raising a new entry request and a return request two cycles into a trap entry. It then checks three things: that exactly one completion arrives, that its handler address belongs to the first vector, and that the access log shows only five accesses. A stack pointer of zero is also driven so that the pushes wrap to the top of the stack segment.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int WORD_W    = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PADDR_W   = WORD_W + SEG_SHIFT;
  localparam logic [WORD_W-1:0] WORD_STEP = WORD_W'(2);

  typedef enum logic [1:0] {
    SRC_HW   = 2'b00,
    SRC_TRAP = 2'b01,
    SRC_EXC  = 2'b10,
    SRC_RSV  = 2'b11
  } src_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP,
    S_TBL_OFF, S_TBL_SEG, S_TBL_WAIT,
    S_POP_IP, S_POP_CS, S_POP_FL, S_POP_WAIT,
    S_DONE
  } seq_state_e;

  // segment:offset to physical byte address
  function automatic logic [PADDR_W-1:0] phys_addr(input logic [WORD_W-1:0] seg,
                                                    input logic [WORD_W-1:0] off);
    return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
  endfunction

  // stack offset n words away from sp (negative for pushes)
  function automatic logic [WORD_W-1:0] stack_off(input logic [WORD_W-1:0] sp,
                                                   input int signed words);
    return sp + WORD_W'(words) * WORD_STEP;
  endfunction
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       ret_req,
  input  logic       enter_is_hw,
  input  logic       if_set,
  output seq_state_e state,
  output logic       accept_enter,
  output logic       accept_ret
);
  seq_state_e nxt;
  logic       idle;

  assign idle         = (state == S_IDLE);
  assign accept_enter = idle && enter_req && (!enter_is_hw || if_set);
  assign accept_ret   = idle && ret_req && !accept_enter;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:     if (accept_enter) nxt = S_PUSH_FL;
                  else if (accept_ret) nxt = S_POP_IP;
      S_PUSH_FL:  nxt = S_PUSH_CS;
      S_PUSH_CS:  nxt = S_PUSH_IP;
      S_PUSH_IP:  nxt = S_TBL_OFF;
      S_TBL_OFF:  nxt = S_TBL_SEG;
      S_TBL_SEG:  nxt = S_TBL_WAIT;
      S_TBL_WAIT: nxt = S_DONE;
      S_POP_IP:   nxt = S_POP_CS;
      S_POP_CS:   nxt = S_POP_FL;
      S_POP_FL:   nxt = S_POP_WAIT;
      S_POP_WAIT: nxt = S_DONE;
      S_DONE:     nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int IF_BIT = 9
)(
  input  logic                clk,
  input  logic                rst_n,
  input  seq_state_e          state,
  input  logic                accept_enter,
  input  logic                accept_ret,
  input  logic [VEC_W-1:0]    enter_vec,
  input  logic                enter_is_hw,
  input  logic [WORD_W-1:0]   cur_cs,
  input  logic [WORD_W-1:0]   cur_ip,
  input  logic [WORD_W-1:0]   cur_flags,
  input  logic [WORD_W-1:0]   cur_ss,
  input  logic [WORD_W-1:0]   cur_sp,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic [WORD_W-1:0]   new_cs,
  output logic [WORD_W-1:0]   new_ip,
  output logic [WORD_W-1:0]   new_flags,
  output logic [WORD_W-1:0]   new_sp,
  output logic                snap_hw,
  output logic                snap_entry,
  output logic [WORD_W-1:0]   snap_flags
);
  localparam logic [WORD_W-1:0] TABLE_SEG = '0;

  logic [VEC_W-1:0]  snap_vec;
  logic [WORD_W-1:0] snap_cs, snap_ip, snap_ss, snap_sp;
  logic [WORD_W-1:0] cap_a, cap_b;

  // byte offset of a table word: vector*4 plus 0 (offset) or 2 (segment)
  function automatic logic [WORD_W-1:0] table_off(input logic [VEC_W-1:0] v,
                                                   input logic hi);
    logic [WORD_W-1:0] t;
    t = '0;
    t[VEC_W+1:0] = {v, 2'b00};
    return hi ? t + WORD_STEP : t;
  endfunction

  function automatic logic [WORD_W-1:0] entry_flags(input logic [WORD_W-1:0] fl,
                                                     input logic hw);
    logic [WORD_W-1:0] r;
    r = fl;
    if (hw) r[IF_BIT] = 1'b0;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_vec <= '0; snap_hw <= 1'b0; snap_entry <= 1'b0;
      snap_cs <= '0; snap_ip <= '0; snap_flags <= '0; snap_ss <= '0; snap_sp <= '0;
    end else if (accept_enter || accept_ret) begin
      snap_vec   <= enter_vec;
      snap_hw    <= accept_enter && enter_is_hw;
      snap_entry <= accept_enter;
      snap_cs    <= cur_cs;
      snap_ip    <= cur_ip;
      snap_flags <= cur_flags;
      snap_ss    <= cur_ss;
      snap_sp    <= cur_sp;
    end
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_FL: begin mem_we = 1'b1; mem_wdata = snap_flags;
                       mem_addr = phys_addr(snap_ss, stack_off(snap_sp, -1)); end
      S_PUSH_CS: begin mem_we = 1'b1; mem_wdata = snap_cs;
                       mem_addr = phys_addr(snap_ss, stack_off(snap_sp, -2)); end
      S_PUSH_IP: begin mem_we = 1'b1; mem_wdata = snap_ip;
                       mem_addr = phys_addr(snap_ss, stack_off(snap_sp, -3)); end
      S_TBL_OFF: mem_addr = phys_addr(TABLE_SEG, table_off(snap_vec, 1'b0));
      S_TBL_SEG: mem_addr = phys_addr(TABLE_SEG, table_off(snap_vec, 1'b1));
      S_POP_IP:  mem_addr = phys_addr(snap_ss, stack_off(snap_sp, 0));
      S_POP_CS:  mem_addr = phys_addr(snap_ss, stack_off(snap_sp, 1));
      S_POP_FL:  mem_addr = phys_addr(snap_ss, stack_off(snap_sp, 2));
      default:   mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0; cap_b <= '0;
      new_cs <= '0; new_ip <= '0; new_flags <= '0; new_sp <= '0;
    end else begin
      unique case (state)
        S_TBL_SEG, S_POP_CS: cap_a <= mem_rdata;
        S_POP_FL:            cap_b <= mem_rdata;
        S_TBL_WAIT: begin
          new_cs    <= mem_rdata;
          new_ip    <= cap_a;
          new_flags <= entry_flags(snap_flags, snap_hw);
          new_sp    <= stack_off(snap_sp, -3);
        end
        S_POP_WAIT: begin
          new_flags <= mem_rdata;
          new_cs    <= cap_b;
          new_ip    <= cap_a;
          new_sp    <= stack_off(snap_sp, 3);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int IF_BIT = 9
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enter_req,
  input  logic [VEC_W-1:0]    enter_vec,
  input  logic [1:0]          enter_kind,
  input  logic                ret_req,
  input  logic [WORD_W-1:0]   cur_cs,
  input  logic [WORD_W-1:0]   cur_ip,
  input  logic [WORD_W-1:0]   cur_flags,
  input  logic [WORD_W-1:0]   cur_ss,
  input  logic [WORD_W-1:0]   cur_sp,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   new_cs,
  output logic [WORD_W-1:0]   new_ip,
  output logic [WORD_W-1:0]   new_flags,
  output logic [WORD_W-1:0]   new_sp
);
  seq_state_e        state;
  logic              accept_enter, accept_ret;
  logic              enter_is_hw;
  logic              snap_hw, snap_entry;
  logic [WORD_W-1:0] snap_flags;

  assign enter_is_hw = (src_kind_e'(enter_kind) == SRC_HW);
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);

  irq_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .ret_req(ret_req),
    .enter_is_hw(enter_is_hw), .if_set(cur_flags[IF_BIT]),
    .state(state), .accept_enter(accept_enter), .accept_ret(accept_ret)
  );

  irq_seq_dp #(.VEC_W(VEC_W), .IF_BIT(IF_BIT)) dp_i (
    .clk(clk), .rst_n(rst_n), .state(state),
    .accept_enter(accept_enter), .accept_ret(accept_ret),
    .enter_vec(enter_vec), .enter_is_hw(enter_is_hw),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_flags(cur_flags),
    .cur_ss(cur_ss), .cur_sp(cur_sp), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags), .new_sp(new_sp),
    .snap_hw(snap_hw), .snap_entry(snap_entry), .snap_flags(snap_flags)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int IF_BIT = 9
)(
  input logic              clk,
  input logic              rst_n,
  input logic              enter_req,
  input logic [1:0]        enter_kind,
  input logic              ret_req,
  input logic [WORD_W-1:0] cur_flags,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] new_flags,
  input logic              accept_enter,
  input logic              accept_ret,
  input logic              snap_hw,
  input logic              snap_entry,
  input logic [WORD_W-1:0] snap_flags
);
  p_hw_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && enter_req && enter_kind == SRC_HW && !cur_flags[IF_BIT] && !ret_req) |=> !busy);

  p_first_push_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_enter |=> (mem_req && mem_we && mem_wdata == $past(cur_flags)));

  p_if_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && snap_entry && snap_hw) |-> !new_flags[IF_BIT]);

  p_flags_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && snap_entry && !snap_hw) |-> (new_flags == snap_flags));

  p_return_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ret |=> (mem_req && !mem_we));

  p_access_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.IF_BIT(IF_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_kind(enter_kind),
  .ret_req(ret_req), .cur_flags(cur_flags), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .busy(busy), .done(done), .new_flags(new_flags),
  .accept_enter(accept_enter), .accept_ret(accept_ret), .snap_hw(snap_hw),
  .snap_entry(snap_entry), .snap_flags(snap_flags)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter_req = 1'b0;
  logic [7:0]  enter_vec = '0;
  logic [1:0]  enter_kind = '0;
  logic        ret_req = 1'b0;
  logic [15:0] cur_cs = '0, cur_ip = '0, cur_flags = '0, cur_ss = '0, cur_sp = '0;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        busy, done;
  logic [15:0] new_cs, new_ip, new_flags, new_sp;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_vec(enter_vec),
    .enter_kind(enter_kind), .ret_req(ret_req), .cur_cs(cur_cs), .cur_ip(cur_ip),
    .cur_flags(cur_flags), .cur_ss(cur_ss), .cur_sp(cur_sp), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .new_cs(new_cs), .new_ip(new_ip),
    .new_flags(new_flags), .new_sp(new_sp)
  );

  // table contents are a fixed function of the address; stack lives in RAM
  function automatic logic [15:0] tbl_word(input logic [19:0] a);
    logic [7:0] v;
    v = a[9:2];
    return a[1] ? {8'h60, v} : (16'h3000 + {8'h00, v} * 16'd7);
  endfunction

  function automatic logic [19:0] pa(input logic [15:0] seg, input logic [15:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  logic [15:0] ram [0:2047];
  logic [19:0] log_addr [0:511];
  logic        log_we   [0:511];
  logic [15:0] log_data [0:511];
  int nlog  = 0;
  int ndone = 0;

  always @(posedge clk) begin
    if (done) ndone <= ndone + 1;
    if (mem_req) begin
      log_addr[nlog % 512] <= mem_addr;
      log_we[nlog % 512]   <= mem_we;
      log_data[nlog % 512] <= mem_wdata;
      nlog <= nlog + 1;
      if (mem_we) ram[mem_addr[11:1]] <= mem_wdata;
      else mem_rdata <= (mem_addr < 20'h400) ? tbl_word(mem_addr) : ram[mem_addr[11:1]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // start an operation at a negedge, return number of cycles until done
  task automatic run_op(input logic do_ret, input logic [1:0] kind, input logic [7:0] vec,
                        input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                        input logic [15:0] ss, input logic [15:0] sp, output int lat);
    int cnt;
    logic busy_ok;
    cur_flags = fl; cur_cs = cs; cur_ip = ip; cur_ss = ss; cur_sp = sp;
    enter_kind = kind; enter_vec = vec;
    enter_req = !do_ret; ret_req = do_ret;
    @(negedge clk);
    enter_req = 1'b0; ret_req = 1'b0;
    cnt = 1; busy_ok = 1'b1;
    while (!done && cnt < 40) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk("R7 busy held until done", {31'd0, busy_ok && busy}, 32'd1);
    lat = cnt;
  endtask

  // kind, vec, flags, cs, ip, sp
  localparam logic [73:0] VECS [0:5] = '{
    {2'b00, 8'h08, 16'h0202, 16'h1234, 16'h5678, 16'h0100},
    {2'b01, 8'h21, 16'h0046, 16'hF000, 16'h0010, 16'h0200},
    {2'b10, 8'h00, 16'h0203, 16'h0001, 16'hFFFE, 16'h0006},
    {2'b00, 8'hFF, 16'hFFFF, 16'hABCD, 16'h0123, 16'h0000},
    {2'b11, 8'h05, 16'h0200, 16'h7777, 16'h8888, 16'h0120},
    {2'b10, 8'h06, 16'h0000, 16'h2222, 16'h3333, 16'h01F0}
  };
  localparam logic [15:0] SS = 16'h0080;

  initial begin
    int lat, l0, d0;
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 busy", {31'd0, busy}, 0);
    chk("R9 done", {31'd0, done}, 0);
    chk("R9 mem_req", {31'd0, mem_req}, 0);
    chk("R9 new regs", {new_cs, new_ip}, 0);
    chk("R9 new regs", {new_flags, new_sp}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [1:0] k; logic [7:0] v; logic [15:0] fl, cs, ip, sp, efl, esp;
      {k, v, fl, cs, ip, sp} = VECS[i];
      efl = fl; if (k == 2'b00) efl[9] = 1'b0;
      esp = sp - 16'd6;
      l0 = nlog;
      run_op(1'b0, k, v, fl, cs, ip, SS, sp, lat);
      chk("R8 entry latency", lat, 7);
      chk("R4 new_ip", new_ip, 16'h3000 + {8'h00, v} * 16'd7);
      chk("R4 new_cs", new_cs, {8'h60, v});
      chk("R5 new_flags", new_flags, efl);
      chk("R2 new_sp", new_sp, esp);
      chk("R2 access count", nlog - l0, 5);
      chk("R2 push flags addr", log_addr[l0 % 512], pa(SS, sp - 16'd2));
      chk("R2 push flags data", {log_we[l0 % 512], log_data[l0 % 512]}, {1'b1, fl});
      chk("R2 push cs addr", log_addr[(l0+1) % 512], pa(SS, sp - 16'd4));
      chk("R2 push cs data", {log_we[(l0+1) % 512], log_data[(l0+1) % 512]}, {1'b1, cs});
      chk("R2 push ip addr", log_addr[(l0+2) % 512], pa(SS, sp - 16'd6));
      chk("R2 push ip data", {log_we[(l0+2) % 512], log_data[(l0+2) % 512]}, {1'b1, ip});
      chk("R3 table offset read", {log_we[(l0+3) % 512], log_addr[(l0+3) % 512]}, {1'b0, 12'd0, v} * 4);
      chk("R3 table segment read", {log_we[(l0+4) % 512], log_addr[(l0+4) % 512]}, {1'b0, 12'd0, v} * 4 + 2);
      @(negedge clk);
      chk("R8 done one cycle", {31'd0, done}, 0);
      chk("R7 busy low after done", {31'd0, busy}, 0);
      // return with scrambled current values
      l0 = nlog;
      run_op(1'b1, 2'b01, 8'h00, 16'h0000, 16'h0000, 16'h0000, SS, esp, lat);
      chk("R8 return latency", lat, 5);
      chk("R6 restored ip", new_ip, ip);
      chk("R6 restored cs", new_cs, cs);
      chk("R6 restored flags", new_flags, fl);
      chk("R6 restored sp", new_sp, sp);
      chk("R6 pop ip addr", {log_we[l0 % 512], log_addr[l0 % 512]}, {1'b0, pa(SS, esp)});
      chk("R6 pop cs addr", {log_we[(l0+1) % 512], log_addr[(l0+1) % 512]}, {1'b0, pa(SS, esp + 16'd2)});
      chk("R6 pop flags addr", {log_we[(l0+2) % 512], log_addr[(l0+2) % 512]}, {1'b0, pa(SS, esp + 16'd4)});
      @(negedge clk);
    end

    // R1: masked hardware request is ignored
    begin
      logic saw_busy;
      l0 = nlog; d0 = ndone; saw_busy = 1'b0;
      cur_flags = 16'h0000; enter_kind = 2'b00; enter_vec = 8'h09; enter_req = 1'b1;
      @(negedge clk);
      enter_req = 1'b0;
      for (int c = 0; c < 10; c++) begin
        if (busy) saw_busy = 1'b1;
        @(negedge clk);
      end
      chk("R1 masked hw busy", {31'd0, saw_busy}, 0);
      chk("R1 masked hw no access", nlog - l0, 0);
      chk("R1 masked hw no done", ndone - d0, 0);
    end

    // R7: requests while busy are ignored
    l0 = nlog; d0 = ndone;
    cur_flags = 16'h0200; cur_cs = 16'h4444; cur_ip = 16'h5555; cur_ss = SS; cur_sp = 16'h0180;
    enter_kind = 2'b01; enter_vec = 8'h10; enter_req = 1'b1;
    @(negedge clk);
    enter_req = 1'b0;
    @(negedge clk);
    enter_vec = 8'h20; enter_kind = 2'b00; cur_sp = 16'h0040; enter_req = 1'b1; ret_req = 1'b1;
    @(negedge clk);
    enter_req = 1'b0; ret_req = 1'b0;
    repeat (15) @(negedge clk);
    chk("R7 single completion", ndone - d0, 1);
    chk("R7 first vector kept", new_ip, 16'h3000 + 16'h0010 * 16'd7);
    chk("R7 first sp kept", new_sp, 16'h017A);
    chk("R7 no extra access", nlog - l0, 5);

    // R1: entry wins over return in the same idle cycle
    l0 = nlog;
    cur_flags = 16'h0200; cur_sp = 16'h0160;
    enter_kind = 2'b10; enter_vec = 8'h33; enter_req = 1'b1; ret_req = 1'b1;
    @(negedge clk);
    enter_req = 1'b0; ret_req = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 entry priority first access is write", {31'd0, log_we[l0 % 512]}, 1);
    chk("R1 entry priority result", new_cs, 16'h6033);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule